// File: doc/BRIEF.md
# Host Controller Status and Interrupt Register

This block holds the status word of a USB 2.0 host controller together with the mask that turns its sticky event bits into an interrupt. Hardware event strobes set six sticky bits. The strobes come from transfer completion, short packets, transaction errors, port change edges, host system errors and the async-advance doorbell handshake. Software clears each bit by writing a one to it. The block watches the frame index and flags a wrap of the frame list. The frame index bit that marks the wrap depends on the configured list size.

The block also reports four read-only state bits. Each is a delayed view of a command or of the schedule engine. The halted flag appears a fixed number of cycles after Run/Stop falls. The periodic and asynchronous schedule status bits follow their enable commands after a programmable delay. The reclamation bit passes straight through from the schedule engine. A host system error sets its status bit and sends a one-cycle request to clear Run/Stop. The schedule engine, descriptor handling and port logic sit outside the block and reach it only as event and level inputs.

Top module: `hc_status_reg`

## Requirements
- R1: After reset, the status word at address 0 reads 0x0000_1000 (only the halted bit 12 set), the enable register at address 1 reads 0, and both `irq_o` and `run_clr_o` are low.
- R2: Bit 0 sets on an interrupt-on-complete retirement or on a short packet, and bit 1 sets on a transaction error. Both set in the same cycle when both strobes coincide. Each bit is visible the cycle after the strobe.
- R3: Bits 5:0 are write-one-to-clear through a write to address 0. A zero in the write data leaves the bit unchanged. Bits 31:6 of the written word have no effect. A hardware set in the same cycle as a clear leaves the bit set.
- R4: Bit 2 sets on a rising edge of `port_chg_i[n]` while `port_local_i[n]` is 1. An edge on a port whose `port_local_i` is 0 does nothing. A change line held high does not set the bit again.
- R5: Bit 3 sets in the cycle after frame index bit (13 - `fl_size_i`) changes value. Size code 0 is a 1024-entry list, code 1 is 512, code 2 is 256 and code 3 is 128. Toggles of other index bits do nothing.
- R6: A host system error strobe sets bit 4 and pulses `run_clr_o` high for one cycle, both visible the cycle after the strobe.
- R7: Bit 5 sets on the first `async_adv_i` strobe after the cycle in which `doorbell_i` was high. An advance with no pending doorbell does nothing, and an advance in the same cycle as the doorbell does not count.
- R8: Bit 12 reads 0 in any cycle where `run_i` is 1. It reads 1 after `run_i` has been low for 4 consecutive clock edges, and 0 after 3.
- R9: Bit 14 (periodic) and bit 15 (asynchronous) take the value of `per_en_i` and `asy_en_i` after that enable has differed from the status for `sched_dly_i`+1 edges. Bit 13 mirrors `reclaim_i`.
- R10: The 6-bit enable register is written through bits 5:0 at address 1. `irq_o` goes high one cycle after a status bit in 5:0 is set while its enable bit is 1. `irq_o` is low whenever no enabled bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 status, 1 interrupt enable |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read select: 0 status, 1 interrupt enable |
| rd_data_o | output | 32 | Read data (combinational) |
| evt_ioc_i | input | 1 | Interrupt-on-complete descriptor retired |
| evt_short_i | input | 1 | Short packet received |
| evt_err_i | input | 1 | Transaction completed with error |
| evt_hse_i | input | 1 | Host system error |
| doorbell_i | input | 1 | Async-advance doorbell written by software |
| async_adv_i | input | 1 | Async schedule advanced |
| port_chg_i | input | NUM_PORTS | Per-port change indication |
| port_local_i | input | NUM_PORTS | Port owned by this controller |
| frindex_i | input | FIDX_W | Frame index counter |
| fl_size_i | input | 2 | Frame list size code |
| run_i | input | 1 | Run/Stop command |
| per_en_i | input | 1 | Periodic schedule enable command |
| asy_en_i | input | 1 | Asynchronous schedule enable command |
| sched_dly_i | input | DLY_W | Schedule status lag minus one |
| reclaim_i | input | 1 | Reclamation flag from schedule engine |
| run_clr_o | output | 1 | Request to clear Run/Stop |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: two ports, a 14-bit frame index, a 4-bit delay field and a 4-cycle halt lag. These values make full sweeps cheap. Every size code is crossed with a toggle of each of the four candidate index bits. All 16 delay settings are driven in both directions on both schedules. All 64 clear masks are applied to a fully set status word. All 64 enable masks are applied against it to check the interrupt. The halt lag is probed at the edges on both sides of the 4-cycle threshold.

// File: rtl/hc_status_pkg.sv
package hc_status_pkg;
  localparam int SRC_N   = 6;
  localparam int B_XFER  = 0;
  localparam int B_ERR   = 1;
  localparam int B_PORT  = 2;
  localparam int B_ROLL  = 3;
  localparam int B_HSE   = 4;
  localparam int B_ADV   = 5;
  localparam int B_HALT  = 12;
  localparam int B_RECL  = 13;
  localparam int B_PER   = 14;
  localparam int B_ASY   = 15;
  localparam int N_SCHED = 2;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/hc_edge_events.sv
module hc_edge_events #(
  parameter int NUM_PORTS = 2,
  parameter int FIDX_W    = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic [NUM_PORTS-1:0] port_local_i,
  input  logic [FIDX_W-1:0]    frindex_i,
  input  logic [1:0]           fl_size_i,
  input  logic                 doorbell_i,
  input  logic                 async_adv_i,
  output logic                 port_evt_o,
  output logic                 roll_evt_o,
  output logic                 adv_evt_o
);
  localparam int TOP_BIT = FIDX_W - 1;

  logic [NUM_PORTS-1:0] chg_q;
  logic [NUM_PORTS-1:0] rise;
  logic                 sel_bit, sel_q, armed_q;

  // wrap marker bit moves down one per size code step
  assign sel_bit = frindex_i[TOP_BIT - int'(fl_size_i)];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rise[p] = port_chg_i[p] & ~chg_q[p] & port_local_i[p];
  end

  assign port_evt_o = |rise;
  assign roll_evt_o = sel_bit ^ sel_q;
  assign adv_evt_o  = armed_q & async_adv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q   <= '0;
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      chg_q <= port_chg_i;
      sel_q <= sel_bit;
      if (doorbell_i)       armed_q <= 1'b1;
      else if (adv_evt_o)   armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_sched_track.sv
module hc_sched_track #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             st_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else if (en_i == st_q) begin
      cnt_q <= '0;
    end else if (cnt_q == dly_i) begin
      st_q  <= en_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/hc_halt_track.sv
module hc_halt_track #(
  parameter int HALT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic halted_o
);
  localparam int CNT_W = $clog2(HALT_CYC) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      halted_q <= 1'b1;
    end else if (run_i) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (cnt_q == LAST) halted_q <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/hc_status_reg.sv
module hc_status_reg
  import hc_status_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int FIDX_W    = 14,
  parameter int DLY_W     = 4,
  parameter int HALT_CYC  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_addr_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 rd_addr_i,
  output logic [31:0]          rd_data_o,
  input  logic                 evt_ioc_i,
  input  logic                 evt_short_i,
  input  logic                 evt_err_i,
  input  logic                 evt_hse_i,
  input  logic                 doorbell_i,
  input  logic                 async_adv_i,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic [NUM_PORTS-1:0] port_local_i,
  input  logic [FIDX_W-1:0]    frindex_i,
  input  logic [1:0]           fl_size_i,
  input  logic                 run_i,
  input  logic                 per_en_i,
  input  logic                 asy_en_i,
  input  logic [DLY_W-1:0]     sched_dly_i,
  input  logic                 reclaim_i,
  output logic                 run_clr_o,
  output logic                 irq_o
);
  src_vec_t sts_q, ien_q, set_vec, clr_vec;
  logic     irq_q, run_clr_q;
  logic     port_evt, roll_evt, adv_evt, halted;
  logic [N_SCHED-1:0] sched_en, sched_st;

  hc_edge_events #(.NUM_PORTS(NUM_PORTS), .FIDX_W(FIDX_W)) u_evt (
    .clk_i, .rst_ni, .port_chg_i, .port_local_i, .frindex_i, .fl_size_i,
    .doorbell_i, .async_adv_i,
    .port_evt_o(port_evt), .roll_evt_o(roll_evt), .adv_evt_o(adv_evt)
  );

  hc_halt_track #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk_i, .rst_ni, .run_i, .halted_o(halted)
  );

  assign sched_en = {asy_en_i, per_en_i};
  for (genvar s = 0; s < N_SCHED; s++) begin : g_sched
    hc_sched_track #(.DLY_W(DLY_W)) u_trk (
      .clk_i, .rst_ni, .en_i(sched_en[s]), .dly_i(sched_dly_i), .st_o(sched_st[s])
    );
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_XFER] = evt_ioc_i | evt_short_i;
    set_vec[B_ERR]  = evt_err_i;
    set_vec[B_PORT] = port_evt;
    set_vec[B_ROLL] = roll_evt;
    set_vec[B_HSE]  = evt_hse_i;
    set_vec[B_ADV]  = adv_evt;
  end

  assign clr_vec = (wr_en_i && !wr_addr_i) ? wr_data_i[SRC_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q     <= '0;
      ien_q     <= '0;
      irq_q     <= 1'b0;
      run_clr_q <= 1'b0;
    end else begin
      sts_q     <= (sts_q & ~clr_vec) | set_vec;
      if (wr_en_i && wr_addr_i) ien_q <= wr_data_i[SRC_N-1:0];
      irq_q     <= |(sts_q & ien_q);
      run_clr_q <= evt_hse_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i) begin
      rd_data_o[SRC_N-1:0] = ien_q;
    end else begin
      rd_data_o[SRC_N-1:0] = sts_q;
      rd_data_o[B_HALT]    = halted & ~run_i;
      rd_data_o[B_RECL]    = reclaim_i;
      rd_data_o[B_PER]     = sched_st[0];
      rd_data_o[B_ASY]     = sched_st[1];
    end
  end

  assign run_clr_o = run_clr_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/hc_status_chk.sv
module hc_status_chk
  import hc_status_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic        evt_hse_i,
  input logic        evt_err_i,
  input logic        wr_en_i,
  input logic        wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        run_clr_o,
  input logic        irq_o,
  input src_vec_t    sts_i,
  input logic        halted_i,
  input logic [1:0]  sched_en_i,
  input logic [1:0]  sched_st_i
);
  AST_HSE_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hse_i |=> (run_clr_o && sts_i[B_HSE])); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_err_i |=> sts_i[B_ERR]); // R2

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(sts_i != '0)); // R10

  AST_HALT_AFTER_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> (!$past(run_i, 1) && !$past(run_i, 2) &&
                         !$past(run_i, 3) && !$past(run_i, 4))); // R8

  for (genvar s = 0; s < 2; s++) begin : g_sched_chk
    AST_SCHED_TOWARD_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sched_st_i[s]) |-> (sched_st_i[s] == $past(sched_en_i[s]))); // R9
  end

  for (genvar b = 0; b < SRC_N; b++) begin : g_w1c_chk
    AST_CLEAR_ONLY_BY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sts_i[b]) |-> $past(wr_en_i && !wr_addr_i && wr_data_i[b])); // R3
  end
endmodule

bind hc_status_reg hc_status_chk u_chk (
  .clk_i, .rst_ni, .run_i, .evt_hse_i, .evt_err_i, .wr_en_i, .wr_addr_i, .wr_data_i,
  .run_clr_o, .irq_o, .sts_i(sts_q), .halted_i(halted),
  .sched_en_i(sched_en), .sched_st_i(sched_st)
);

// File: tb/hc_status_reg_tb_top.sv
module hc_status_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 0, wr_addr_i = 0, rd_addr_i = 0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic        evt_ioc_i = 0, evt_short_i = 0, evt_err_i = 0, evt_hse_i = 0;
  logic        doorbell_i = 0, async_adv_i = 0;
  logic [1:0]  port_chg_i = '0, port_local_i = '0;
  logic [13:0] frindex_i = '0;
  logic [1:0]  fl_size_i = '0;
  logic        run_i = 0, per_en_i = 0, asy_en_i = 0, reclaim_i = 0;
  logic [3:0]  sched_dly_i = '0;
  logic        run_clr_o, irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  hc_status_reg dut_i (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic w1c(input logic [31:0] m);
    wr_en_i = 1; wr_addr_i = 0; wr_data_i = m;
    tick();
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic wien(input logic [31:0] m);
    wr_en_i = 1; wr_addr_i = 1; wr_data_i = m;
    tick();
    wr_en_i = 0; wr_addr_i = 0; wr_data_i = '0;
  endtask

  task automatic set_all();
    fl_size_i = 0; doorbell_i = 1; port_chg_i = '0; port_local_i = 2'b01;
    tick();
    doorbell_i = 0; async_adv_i = 1; evt_ioc_i = 1; evt_err_i = 1; evt_hse_i = 1;
    port_chg_i = 2'b01; frindex_i = frindex_i ^ 14'h2000;
    tick();
    async_adv_i = 0; evt_ioc_i = 0; evt_err_i = 0; evt_hse_i = 0; port_chg_i = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] hi;
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1
    chk("R1 status", rd_data_o, 32'h0000_1000);
    rd_addr_i = 1; #1;
    chk("R1 enable", rd_data_o, 32'h0);
    rd_addr_i = 0; #1;
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 run_clr", {31'b0, run_clr_o}, 32'h0);

    // R8
    run_i = 1; #1;
    chk("R8 run high", {31'b0, rd_data_o[12]}, 32'h0);
    tick(); tick();
    run_i = 0;
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk("R8 before lag", {31'b0, rd_data_o[12]}, 32'h0);
    end
    tick();
    chk("R8 after lag", {31'b0, rd_data_o[12]}, 32'h1);

    // R2
    evt_ioc_i = 1; tick(); evt_ioc_i = 0;
    chk("R2 ioc", {26'b0, rd_data_o[5:0]}, 32'h01); w1c(32'h3F);
    evt_short_i = 1; tick(); evt_short_i = 0;
    chk("R2 short", {26'b0, rd_data_o[5:0]}, 32'h01); w1c(32'h3F);
    evt_err_i = 1; tick(); evt_err_i = 0;
    chk("R2 err", {26'b0, rd_data_o[5:0]}, 32'h02); w1c(32'h3F);
    evt_ioc_i = 1; evt_err_i = 1; tick(); evt_ioc_i = 0; evt_err_i = 0;
    chk("R2 both", {26'b0, rd_data_o[5:0]}, 32'h03); w1c(32'h3F);

    // R3
    set_all();
    evt_err_i = 1; w1c(32'h3F); evt_err_i = 0;
    chk("R3 set wins", {26'b0, rd_data_o[5:0]}, 32'h02);
    w1c(32'h3F);
    set_all();
    hi = rd_data_o[15:12];
    w1c(32'hFFFF_FFC0);
    chk("R3 upper write ignored", {26'b0, rd_data_o[5:0]}, 32'h3F);
    chk("R3 ro bits", {28'b0, rd_data_o[15:12]}, {28'b0, hi});
    for (int m = 0; m < 64; m++) begin
      set_all();
      w1c(m);
      chk("R3 w1c mask", {26'b0, rd_data_o[5:0]}, 32'(~m & 6'h3F));
      w1c(32'h3F);
    end

    // R4
    port_local_i = 2'b01; port_chg_i = 2'b00; tick();
    port_chg_i = 2'b01; tick();
    chk("R4 owned edge", {31'b0, rd_data_o[2]}, 32'h1);
    w1c(32'h04); tick();
    chk("R4 held level", {31'b0, rd_data_o[2]}, 32'h0);
    port_chg_i = 2'b11; tick();
    chk("R4 unowned edge", {31'b0, rd_data_o[2]}, 32'h0);
    port_chg_i = 2'b00; tick();

    // R5
    for (int fs = 0; fs < 4; fs++) begin
      for (int b = 10; b <= 13; b++) begin
        frindex_i = '0; fl_size_i = 2'(fs); tick(); tick(); w1c(32'h3F);
        frindex_i = 14'(1 << b); tick();
        chk("R5 toggle up", {31'b0, rd_data_o[3]}, {31'b0, b == 13 - fs});
        w1c(32'h08);
        frindex_i = '0; tick();
        chk("R5 toggle down", {31'b0, rd_data_o[3]}, {31'b0, b == 13 - fs});
        w1c(32'h3F);
      end
    end
    fl_size_i = 0; tick();

    // R6
    evt_hse_i = 1; tick(); evt_hse_i = 0;
    chk("R6 bit", {31'b0, rd_data_o[4]}, 32'h1);
    chk("R6 run_clr", {31'b0, run_clr_o}, 32'h1);
    tick();
    chk("R6 pulse ends", {31'b0, run_clr_o}, 32'h0);
    w1c(32'h3F);

    // R7
    async_adv_i = 1; tick(); async_adv_i = 0;
    chk("R7 no doorbell", {31'b0, rd_data_o[5]}, 32'h0);
    doorbell_i = 1; async_adv_i = 1; tick(); doorbell_i = 0;
    chk("R7 same cycle", {31'b0, rd_data_o[5]}, 32'h0);
    tick(); async_adv_i = 0;
    chk("R7 armed advance", {31'b0, rd_data_o[5]}, 32'h1);
    w1c(32'h20);
    async_adv_i = 1; tick(); async_adv_i = 0;
    chk("R7 consumed", {31'b0, rd_data_o[5]}, 32'h0);

    // R9
    for (int d = 0; d < 16; d++) begin
      sched_dly_i = 4'(d);
      per_en_i = 1; asy_en_i = 1;
      for (int i = 0; i < d; i++) begin
        tick(); chk("R9 on lag", {30'b0, rd_data_o[15:14]}, 32'h0);
      end
      tick(); chk("R9 on", {30'b0, rd_data_o[15:14]}, 32'h3);
      per_en_i = 0;
      for (int i = 0; i < d; i++) begin
        tick(); chk("R9 per off lag", {30'b0, rd_data_o[15:14]}, 32'h3);
      end
      tick(); chk("R9 per off", {30'b0, rd_data_o[15:14]}, 32'h2);
      asy_en_i = 0;
      for (int i = 0; i <= d; i++) tick();
      chk("R9 asy off", {30'b0, rd_data_o[15:14]}, 32'h0);
    end
    reclaim_i = 1; #1;
    chk("R9 reclaim", {31'b0, rd_data_o[13]}, 32'h1);
    reclaim_i = 0; #1;
    chk("R9 reclaim low", {31'b0, rd_data_o[13]}, 32'h0);

    // R10
    w1c(32'h3F); wien(32'h01); tick();
    chk("R10 idle", {31'b0, irq_o}, 32'h0);
    evt_ioc_i = 1; tick(); evt_ioc_i = 0;
    chk("R10 lag", {31'b0, irq_o}, 32'h0);
    tick();
    chk("R10 asserted", {31'b0, irq_o}, 32'h1);
    w1c(32'h3F); tick();
    chk("R10 released", {31'b0, irq_o}, 32'h0);
    set_all();
    for (int m = 0; m < 64; m++) begin
      wien(32'hFFFF_FFC0 | m); tick();
      chk("R10 mask irq", {31'b0, irq_o}, {31'b0, m != 0});
      rd_addr_i = 1; #1;
      chk("R10 enable read", rd_data_o, 32'(m));
      rd_addr_i = 0; #1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule